// File: doc/BRIEF.md
# Debug Event Response Controller

This block decides what the core does when one or more instruction-address-compare units signal a match. The decision depends on the debug mode in force. Halting debug means either external debug or debug-wait is active. In that mode a match records a status bit, blocks the instruction from executing, and asks the core to stop. In internal debug mode with debug interrupts enabled, a match records status, blocks the instruction and raises a debug interrupt. In both of these cases the address of the offending instruction is captured as the return address.

In internal debug mode with debug interrupts disabled, only exact-compare matches are kept. Each one sets its event bit and an imprecise flag, and the instruction runs on. When the interrupt enable later rises, the block raises a deferred debug interrupt, but only if software has left the status in place. Status bits are sticky and are cleared by a write-one-to-clear. The stop request and the interrupt request each stay high until their own acknowledge arrives.

Top module: `dbg_event_resp`

## Requirements
- R1: When external debug or debug-wait is active, a match drives `suppress` high in the same cycle. On the next clock the block sets the matching event bits, sets `stop_req` and loads `ret_addr` with `evt_addr`.
- R2: When internal debug is active with `int_en`=1 and halting debug is not active, a match drives `suppress` high in the same cycle. On the next clock the block sets the matching event bits, sets `dbg_irq` and loads `ret_addr` with `evt_addr`.
- R3: Halting debug takes priority over internal debug. While it is active, a match never raises `dbg_irq`.
- R4: When internal debug is active with `int_en`=0 and halting debug is not active, an exact-mode match sets its event bit and the imprecise bit, which is `status[NUM_CMP]`. `suppress` stays low, no request is raised, and `ret_addr` is unchanged.
- R5: In the mode of R4, a range-mode match (`evt_exact` bit 0) is ignored and leaves `status` unchanged.
- R6: On the first cycle that `int_en` is 1 after being 0, a deferred `dbg_irq` is raised on the next clock if all of these hold: internal debug is active, halting debug is not, the imprecise bit is set, and at least one event bit is set.
- R7: If software has cleared the event bits before `int_en` rises, no deferred interrupt is raised.
- R8: Status bits are sticky. A clear write with a 1 in a bit position clears that bit, and a 0 leaves it unchanged. A set in the same cycle as a clear wins.
- R9: `stop_req` and `dbg_irq` stay high until `stop_ack` and `irq_ack` respectively. A new request in the same cycle as the acknowledge keeps the request high.
- R10: With no debug mode active, a match has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_hit | input | NUM_CMP | One bit per compare unit, pulses on a match |
| evt_exact | input | NUM_CMP | Per unit, 1 for exact-compare mode and 0 for range mode |
| evt_addr | input | ADDR_W | Address of the matching instruction |
| mode_ext | input | 1 | External debug mode active |
| mode_wait | input | 1 | Debug-wait mode active |
| mode_int | input | 1 | Internal debug mode active |
| int_en | input | 1 | Debug interrupt enable |
| clr_we | input | 1 | Status clear strobe |
| clr_data | input | NUM_CMP+1 | Write-one-to-clear mask; bit NUM_CMP is the imprecise bit |
| stop_ack | input | 1 | Acknowledge for the stop request |
| irq_ack | input | 1 | Acknowledge for the interrupt request |
| suppress | output | 1 | Block the matching instruction (combinational) |
| stop_req | output | 1 | Held stop request |
| dbg_irq | output | 1 | Held debug interrupt request |
| ret_addr | output | ADDR_W | Captured address of the offending instruction |
| status | output | NUM_CMP+1 | Sticky event bits, with the imprecise bit on top |

## Verification
The assertions assume that the mode flags, `int_en`, `evt_exact` and `evt_addr` are stable across the cycle in which a match is presented. They also assume that the acknowledges are only pulsed while the matching request is high. The bench changes modes only in cycles without a match, and it clears the status with the modes off before each trial, so a mode change never turns into a stray deferred interrupt. Acknowledges are sent as single-cycle pulses after the request has been observed.

// File: rtl/dbg_resp_pkg.sv
package dbg_resp_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_HALT   = 2'd1,
    ACT_INTR   = 2'd2,
    ACT_RECORD = 2'd3
  } act_e;

  // Response chosen for the current mode flags; halting debug wins.
  function automatic act_e pick_action(input logic halt_mode,
                                       input logic int_mode,
                                       input logic irq_enable);
    if (halt_mode)                    return ACT_HALT;
    else if (int_mode && irq_enable)  return ACT_INTR;
    else if (int_mode)                return ACT_RECORD;
    else                              return ACT_NONE;
  endfunction

  // Sticky update: keep unless cleared; a set always wins.
  function automatic logic sticky_next(input logic cur, input logic set_b,
                                       input logic clr_b);
    return (cur & ~clr_b) | set_b;
  endfunction

  // Held request: keep until acknowledged; a new request wins.
  function automatic logic hold_next(input logic cur, input logic set_b,
                                     input logic ack_b);
    return (cur & ~ack_b) | set_b;
  endfunction

endpackage

// File: rtl/dbg_resp_decode.sv
module dbg_resp_decode
  import dbg_resp_pkg::*;
#(
  parameter int NUM_CMP = 4
) (
  input  logic [NUM_CMP-1:0] hit,
  input  logic [NUM_CMP-1:0] exact,
  input  logic               halt_mode,
  input  logic               int_mode,
  input  logic               irq_enable,
  output logic [NUM_CMP-1:0] set_mask,
  output logic               set_imp,
  output logic               suppress,
  output logic               take_halt,
  output logic               take_intr
);

  act_e act;
  logic any_hit;

  assign act     = pick_action(halt_mode, int_mode, irq_enable);
  assign any_hit = |hit;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_mask
    always_comb begin
      unique case (act)
        ACT_HALT, ACT_INTR: set_mask[i] = hit[i];
        ACT_RECORD:         set_mask[i] = hit[i] & exact[i];
        default:            set_mask[i] = 1'b0;
      endcase
    end
  end

  assign set_imp   = (act == ACT_RECORD) && |(hit & exact);
  assign take_halt = (act == ACT_HALT) && any_hit;
  assign take_intr = (act == ACT_INTR) && any_hit;
  assign suppress  = take_halt | take_intr;

endmodule

// File: rtl/dbg_resp_status.sv
module dbg_resp_status
  import dbg_resp_pkg::*;
#(
  parameter int NUM_CMP = 4,
  localparam int ST_W = NUM_CMP + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CMP-1:0] set_mask,
  input  logic               set_imp,
  input  logic               clr_we,
  input  logic [ST_W-1:0]    clr_data,
  output logic [ST_W-1:0]    status
);

  logic [ST_W-1:0] set_all;
  logic [ST_W-1:0] clr_all;

  assign set_all = {set_imp, set_mask};
  assign clr_all = clr_we ? clr_data : '0;

  for (genvar i = 0; i < ST_W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status[i] <= 1'b0;
      else        status[i] <= sticky_next(status[i], set_all[i], clr_all[i]);
    end
  end

  // A bit that was set and not cleared stays set.
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status) & ~$past(clr_all) & ~status) == '0));

  // A bit can only rise when it was asked to be set.
  assert_set_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(set_all)) == '0));

endmodule

// File: rtl/dbg_resp_req.sv
module dbg_resp_req
  import dbg_resp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_halt,
  input  logic              take_intr,
  input  logic              dly_intr,
  input  logic              stop_ack,
  input  logic              irq_ack,
  input  logic [ADDR_W-1:0] evt_addr,
  output logic              stop_req,
  output logic              dbg_irq,
  output logic [ADDR_W-1:0] ret_addr
);

  logic capture;
  assign capture = take_halt | take_intr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_req <= 1'b0;
      dbg_irq  <= 1'b0;
      ret_addr <= '0;
    end else begin
      stop_req <= hold_next(stop_req, take_halt, stop_ack);
      dbg_irq  <= hold_next(dbg_irq, take_intr | dly_intr, irq_ack);
      if (capture) ret_addr <= evt_addr;
    end
  end

  assert_stop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req && !stop_ack |=> stop_req);

  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_irq && !irq_ack |=> dbg_irq);

  assert_ret_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take_halt |=> stop_req && ret_addr == $past(evt_addr));

  assert_ret_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_intr |=> dbg_irq && ret_addr == $past(evt_addr));

  assert_ret_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(ret_addr));

endmodule

// File: rtl/dbg_event_resp.sv
module dbg_event_resp
  import dbg_resp_pkg::*;
#(
  parameter int NUM_CMP = 4,
  parameter int ADDR_W  = 32,
  localparam int ST_W = NUM_CMP + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CMP-1:0] evt_hit,
  input  logic [NUM_CMP-1:0] evt_exact,
  input  logic [ADDR_W-1:0]  evt_addr,
  input  logic               mode_ext,
  input  logic               mode_wait,
  input  logic               mode_int,
  input  logic               int_en,
  input  logic               clr_we,
  input  logic [ST_W-1:0]    clr_data,
  input  logic               stop_ack,
  input  logic               irq_ack,
  output logic               suppress,
  output logic               stop_req,
  output logic               dbg_irq,
  output logic [ADDR_W-1:0]  ret_addr,
  output logic [ST_W-1:0]    status
);

  logic               halt_mode;
  logic [NUM_CMP-1:0] set_mask;
  logic               set_imp;
  logic               take_halt;
  logic               take_intr;
  logic               int_en_q;
  logic               en_rise;
  logic               pend_ok;
  logic               dly_intr;

  assign halt_mode = mode_ext | mode_wait;

  dbg_resp_decode #(.NUM_CMP(NUM_CMP)) u_decode (
    .hit        (evt_hit),
    .exact      (evt_exact),
    .halt_mode  (halt_mode),
    .int_mode   (mode_int),
    .irq_enable (int_en),
    .set_mask   (set_mask),
    .set_imp    (set_imp),
    .suppress   (suppress),
    .take_halt  (take_halt),
    .take_intr  (take_intr)
  );

  dbg_resp_status #(.NUM_CMP(NUM_CMP)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_mask (set_mask),
    .set_imp  (set_imp),
    .clr_we   (clr_we),
    .clr_data (clr_data),
    .status   (status)
  );

  // Deferred interrupt: enable rising edge with a recorded imprecise event.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_en_q <= 1'b0;
    else        int_en_q <= int_en;
  end

  assign en_rise  = int_en & ~int_en_q;
  assign pend_ok  = status[NUM_CMP] & |status[NUM_CMP-1:0];
  assign dly_intr = en_rise & mode_int & ~halt_mode & pend_ok;

  dbg_resp_req #(.ADDR_W(ADDR_W)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_halt (take_halt),
    .take_intr (take_intr),
    .dly_intr  (dly_intr),
    .stop_ack  (stop_ack),
    .irq_ack   (irq_ack),
    .evt_addr  (evt_addr),
    .stop_req  (stop_req),
    .dbg_irq   (dbg_irq),
    .ret_addr  (ret_addr)
  );

  assert_halt_no_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    halt_mode && !dly_intr |=> !$rose(dbg_irq));

  assert_halt_suppress_R1: assert property (@(posedge clk) disable iff (!rst_n)
    halt_mode && |evt_hit |-> suppress);

  assert_record_no_suppress_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_int && !int_en && !halt_mode |-> !suppress);

  assert_range_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_int && !int_en && !halt_mode && !clr_we && ((evt_hit & evt_exact) == '0)
    |=> $stable(status));

  assert_deferred_needs_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_irq && !take_intr && !pend_ok |=> !dbg_irq);

  assert_deferred_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dly_intr |=> dbg_irq);

  assert_idle_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_mode && !mode_int |-> !suppress);

endmodule

// File: tb/dbg_event_resp_bench.sv
module dbg_event_resp_bench;
  localparam int NC = 2;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0] evt_hit = '0, evt_exact = '0;
  logic [AW-1:0] evt_addr = '0;
  logic mode_ext = 0, mode_wait = 0, mode_int = 0, int_en = 0;
  logic clr_we = 0;
  logic [NC:0] clr_data = '0;
  logic stop_ack = 0, irq_ack = 0;
  logic suppress, stop_req, dbg_irq;
  logic [AW-1:0] ret_addr;
  logic [NC:0] status;

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] exp_ret = '0;

  always #2.5 clk = ~clk;

  dbg_event_resp #(.NUM_CMP(NC), .ADDR_W(AW)) u_dbg_event_resp (
    .clk(clk), .rst_n(rst_n), .evt_hit(evt_hit), .evt_exact(evt_exact),
    .evt_addr(evt_addr), .mode_ext(mode_ext), .mode_wait(mode_wait),
    .mode_int(mode_int), .int_en(int_en), .clr_we(clr_we), .clr_data(clr_data),
    .stop_ack(stop_ack), .irq_ack(irq_ack), .suppress(suppress),
    .stop_req(stop_req), .dbg_irq(dbg_irq), .ret_addr(ret_addr), .status(status)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Advance one clock and land 1 ns after the edge.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_modes(input bit e, input bit w, input bit i, input bit en);
    mode_ext = e; mode_wait = w; mode_int = i; int_en = en;
  endtask

  // Modes off, clear all status, acknowledge both requests.
  task automatic scrub();
    set_modes(0, 0, 0, 0);
    clr_we = 1; clr_data = '1; stop_ack = 1; irq_ack = 1;
    tick();
    clr_we = 0; clr_data = '0; stop_ack = 0; irq_ack = 0;
    tick();
  endtask

  initial begin
    #20000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #7;
    check(status == '0 && !stop_req && !dbg_irq && ret_addr == '0, "R8",
          "reset state", {status, stop_req, dbg_irq}, 0);
    rst_n = 1'b1;
    tick();

    // Sweep every mode combination, both compare modes, both channels.
    for (int m = 0; m < 16; m++) begin
      for (int ex = 0; ex < 2; ex++) begin
        for (int ch = 0; ch < NC; ch++) begin
          bit e, w, i, en, halt, take, rec;
          logic [NC:0] exp_st;
          string tag;
          e = m[0]; w = m[1]; i = m[2]; en = m[3];
          halt = e | w;
          take = halt | (i & en);
          rec  = !halt & i & !en & (ex == 1);
          if (halt && i) tag = "R3";
          else if (halt) tag = "R1";
          else if (i && en) tag = "R2";
          else if (rec) tag = "R4";
          else if (i) tag = "R5";
          else tag = "R10";
          scrub();
          set_modes(e, w, i, en);
          tick();
          evt_hit = NC'(1 << ch);
          evt_exact = ex ? '1 : '0;
          evt_addr = AW'(16'h1000 + m * 64 + ex * 8 + ch * 4);
          #1;
          check(suppress == take, tag, "suppress", suppress, take);
          tick();
          exp_st = '0;
          if (take || rec) exp_st[ch] = 1'b1;
          if (rec) exp_st[NC] = 1'b1;
          if (take) exp_ret = evt_addr;
          evt_hit = '0;
          check(status == exp_st, tag, "status", status, exp_st);
          check(stop_req == halt, tag, "stop_req", stop_req, halt);
          check(dbg_irq == (!halt & i & en), tag, "dbg_irq", dbg_irq, !halt & i & en);
          check(ret_addr == exp_ret, tag, "ret_addr", ret_addr, exp_ret);
        end
      end
    end

    // R6: imprecise event, then enable rises -> deferred interrupt.
    scrub();
    set_modes(0, 0, 1, 0); tick();
    evt_hit = 2'b01; evt_exact = 2'b01; tick();
    evt_hit = '0;
    check(status == 3'b101, "R6", "recorded status", status, 3'b101);
    tick();
    check(!dbg_irq, "R6", "no irq before enable", dbg_irq, 0);
    int_en = 1; tick();
    check(dbg_irq, "R6", "deferred irq", dbg_irq, 1);
    check(ret_addr == exp_ret, "R6", "ret unchanged", ret_addr, exp_ret);

    // R9: held until ack, ack clears.
    repeat (5) tick();
    check(dbg_irq, "R9", "irq held", dbg_irq, 1);
    irq_ack = 1; tick(); irq_ack = 0;
    check(!dbg_irq, "R9", "irq acked", dbg_irq, 0);

    // R7: clear event bits before enabling -> no deferred interrupt.
    scrub();
    set_modes(0, 0, 1, 0); tick();
    evt_hit = 2'b10; evt_exact = 2'b10; tick();
    evt_hit = '0;
    clr_we = 1; clr_data = 3'b010; tick(); clr_we = 0; clr_data = '0;
    check(status == 3'b100, "R7", "event bit cleared", status, 3'b100);
    int_en = 1; tick(); tick();
    check(!dbg_irq, "R7", "no deferred irq", dbg_irq, 0);

    // R8: zero write has no effect; partial clear; set wins over clear.
    scrub();
    set_modes(1, 0, 0, 0); tick();
    evt_hit = 2'b11; evt_addr = 16'hBEEF; tick();
    evt_hit = '0; exp_ret = 16'hBEEF;
    check(status == 3'b011, "R1", "multi-hit status", status, 3'b011);
    check(ret_addr == 16'hBEEF, "R1", "ret addr", ret_addr, 16'hBEEF);
    clr_we = 1; clr_data = 3'b000; tick();
    check(status == 3'b011, "R8", "zero write", status, 3'b011);
    clr_data = 3'b001; tick(); clr_we = 0;
    check(status == 3'b010, "R8", "partial clear", status, 3'b010);
    evt_hit = 2'b01; clr_we = 1; clr_data = 3'b011; tick();
    evt_hit = '0; clr_we = 0; clr_data = '0;
    check(status == 3'b001, "R8", "set wins", status, 3'b001);

    // R9: stop held; ack with new event keeps it.
    repeat (3) tick();
    check(stop_req, "R9", "stop held", stop_req, 1);
    stop_ack = 1; evt_hit = 2'b10; tick();
    stop_ack = 0; evt_hit = '0;
    check(stop_req, "R9", "new request wins", stop_req, 1);
    stop_ack = 1; tick(); stop_ack = 0;
    check(!stop_req, "R9", "stop acked", stop_req, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule